// File: doc/BRIEF.md
# Geared Multiturn Stage Position Synchronizer

This block sits in one stage of a chain of absolute angle sensors. Each stage is coupled to the next by a 1:16 reduction gear, so the upper four bits of a faster stage cover the same angle as the lower four bits of the slower stage after it. The block takes the stage's raw 8-bit angle and the upper nibble of the preceding stage's corrected angle. It adds a per-stage offset to the raw angle and passes the corrected upper nibble on to the next stage. Once synchronization is enabled, it replaces the 8-bit reading with a 4-bit turn count, aligned to the finer stage.

Calibration runs one stage at a time, starting at the single-turn end of the chain. The stage is first configured with synchronization off, offset zero and the full-length code. A calibrate strobe then captures, in one clock, the offset that places this stage's corrected lower nibble four steps (a quarter of a revolution) ahead of the preceding stage's nibble. The stage is then switched to synchronized 4-bit output. An optional monitor flags readings whose nibble overlap has drifted past the quarter-turn reserve.

All outputs are registered, so each one reflects the inputs and configuration present at the previous rising clock edge.

Top module: `gear_stage_sync`

## Requirements
- R1: While reset is asserted, and after it is released, the mode and offset registers are cleared (sync off, check off, code 0, offset 0), and pos_out, next_hi and sync_err are 0.
- R2: A cfg_wr pulse loads cfg_sync_en, cfg_chk_en, cfg_dlc and cfg_offset at the clock edge. If cal_strobe is accepted in the same cycle, the calibrated offset takes priority over cfg_offset.
- R3: Unless the sync bit is set and the code is 3'h3, pos_out equals (raw_pos + offset) mod 256, one clock after the input.
- R4: In every mode, next_hi equals bits 7..4 of (raw_pos + offset) mod 256, one clock after the input.
- R5: When the sync bit is clear, cal_strobe loads the offset with the zero-extended nibble (prev_hi − raw_pos[3:0] + 4) mod 16.
- R6: When the sync bit is set, cal_strobe is ignored and the offset keeps its value.
- R7: When the sync bit is set and the code is 3'h3, pos_out[3:0] is the turn count and pos_out[7:4] is 0. Let t = raw_pos + offset − 4 (mod 256) and let d = t[3:0] − prev_hi, read as a signed 4-bit value. The turn count is bits 7..4 of (t − sign-extended d) mod 256.
- R8: When the check bit is set and the code is 3'h3, sync_err is 1 one clock later if d > 4 or d < −4, and 0 otherwise.
- R9: When the check bit is clear, or the code is not 3'h3, sync_err is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| raw_pos | input | 8 | Raw angle of this stage |
| prev_hi | input | 4 | Corrected upper nibble of the preceding, finer stage |
| cfg_wr | input | 1 | Write strobe for the mode fields and the offset |
| cfg_sync_en | input | 1 | Sync enable value to load |
| cfg_chk_en | input | 1 | Consistency check enable value to load |
| cfg_dlc | input | 3 | Data-length code to load (3'h7 full, 3'h3 synchronized) |
| cfg_offset | input | 8 | Offset value to load |
| cal_strobe | input | 1 | Capture the calibration offset |
| pos_out | output | 8 | Corrected angle, or the turn count in bits 3..0 |
| next_hi | output | 4 | Corrected upper nibble passed to the next stage |
| sync_err | output | 1 | Overlap consistency error |

## Verification
The bench builds the block with its default parameters: 8-bit positions, 4-bit overlap nibbles and a reserve of 4. With these values every raw angle, offset and neighbour nibble can be reached, so random stimulus covers all sixteen values of the signed deviation. Directed cases pin down the limits d = ±4 (no error), d = 5 and d = −8 (error), and a neighbour wrap from 15 to 0 that moves the turn count up by one. The random stream also mixes the codes 3'h3, 3'h7 and other codes with every combination of the sync and check bits. This shows that only the exact code 3'h3 selects the turn count and enables the monitor.

// File: rtl/gss_pkg.sv
package gss_pkg;

  localparam int DLC_W = 3;
  localparam logic [DLC_W-1:0] DLC_FULL = 3'h7;
  localparam logic [DLC_W-1:0] DLC_SYNC = 3'h3;

  typedef struct packed {
    logic             sync_en;
    logic             chk_en;
    logic [DLC_W-1:0] dlc;
  } stage_mode_t;

endpackage

// File: rtl/gss_cfg_regs.sv
module gss_cfg_regs
  import gss_pkg::*;
#(
  parameter int POS_W   = 8,
  parameter int NIB_W   = 4,
  parameter int RESERVE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  stage_mode_t       cfg_mode,
  input  logic [POS_W-1:0]  cfg_offset,
  input  logic              cal_strobe,
  input  logic [NIB_W-1:0]  raw_lo,
  input  logic [NIB_W-1:0]  prev_hi,
  output stage_mode_t       mode_q,
  output logic [POS_W-1:0]  off_q
);

  logic [NIB_W-1:0] cal_nib;
  logic             cal_ok;
  logic             mode_en;
  logic             off_en;
  stage_mode_t      mode_d;
  logic [POS_W-1:0] off_d;

  // next-state
  always_comb begin
    cal_nib = prev_hi - raw_lo + NIB_W'(RESERVE);
    cal_ok  = cal_strobe && !mode_q.sync_en;
    mode_en = cfg_wr;
    off_en  = cal_ok || cfg_wr;
    mode_d  = cfg_mode;
    if (cal_ok) begin
      off_d = POS_W'(cal_nib);
    end else begin
      off_d = cfg_offset;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      off_q  <= '0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      if (off_en)  off_q  <= off_d;
    end
  end

endmodule

// File: rtl/gss_align.sv
module gss_align #(
  parameter int POS_W   = 8,
  parameter int NIB_W   = 4,
  parameter int RESERVE = 4,
  localparam int HI_W   = POS_W - NIB_W
) (
  input  logic [POS_W-1:0] raw_pos,
  input  logic [POS_W-1:0] off_q,
  input  logic [NIB_W-1:0] prev_hi,
  output logic [POS_W-1:0] corr,
  output logic [HI_W-1:0]  turn,
  output logic             dev_big
);

  localparam logic signed [NIB_W:0] RES_S = (NIB_W+1)'(RESERVE);

  logic [POS_W-1:0]        shifted;
  logic [NIB_W-1:0]        dev;
  logic signed [NIB_W:0]   dev_s;
  logic [POS_W-1:0]        aligned;

  always_comb begin
    corr    = raw_pos + off_q;
    shifted = corr - POS_W'(RESERVE);
    dev     = shifted[NIB_W-1:0] - prev_hi;
    dev_s   = {dev[NIB_W-1], dev};
    aligned = shifted - {{(POS_W-NIB_W){dev[NIB_W-1]}}, dev};
    turn    = aligned[POS_W-1:NIB_W];
    dev_big = (dev_s > RES_S) || (dev_s < -RES_S);
  end

endmodule

// File: rtl/gss_out.sv
module gss_out
  import gss_pkg::*;
#(
  parameter int POS_W  = 8,
  parameter int NIB_W  = 4,
  localparam int HI_W  = POS_W - NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stage_mode_t       mode_q,
  input  logic [POS_W-1:0]  corr,
  input  logic [HI_W-1:0]   turn,
  input  logic              dev_big,
  output logic [POS_W-1:0]  pos_q,
  output logic [NIB_W-1:0]  hi_q,
  output logic              err_q
);

  logic             sync_sel;
  logic             chk_sel;
  logic             out_en;
  logic [POS_W-1:0] pos_d;
  logic [NIB_W-1:0] hi_d;
  logic             err_d;

  // next-state
  always_comb begin
    sync_sel = mode_q.sync_en && (mode_q.dlc == DLC_SYNC);
    chk_sel  = mode_q.chk_en && (mode_q.dlc == DLC_SYNC);
    out_en   = 1'b1;
    pos_d    = sync_sel ? POS_W'(turn) : corr;
    hi_d     = corr[POS_W-1 -: NIB_W];
    err_d    = chk_sel && dev_big;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      hi_q  <= '0;
      err_q <= 1'b0;
    end else if (out_en) begin
      pos_q <= pos_d;
      hi_q  <= hi_d;
      err_q <= err_d;
    end
  end

endmodule

// File: rtl/gear_stage_sync.sv
module gear_stage_sync
  import gss_pkg::*;
#(
  parameter int POS_W   = 8,
  parameter int NIB_W   = 4,
  parameter int RESERVE = 4,
  localparam int HI_W   = POS_W - NIB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] raw_pos,
  input  logic [NIB_W-1:0] prev_hi,
  input  logic             cfg_wr,
  input  logic             cfg_sync_en,
  input  logic             cfg_chk_en,
  input  logic [DLC_W-1:0] cfg_dlc,
  input  logic [POS_W-1:0] cfg_offset,
  input  logic             cal_strobe,
  output logic [POS_W-1:0] pos_out,
  output logic [NIB_W-1:0] next_hi,
  output logic             sync_err
);

  stage_mode_t      cfg_mode;
  stage_mode_t      mode_q;
  logic [POS_W-1:0] off_q;
  logic [POS_W-1:0] corr;
  logic [HI_W-1:0]  turn;
  logic             dev_big;

  always_comb begin
    cfg_mode.sync_en = cfg_sync_en;
    cfg_mode.chk_en  = cfg_chk_en;
    cfg_mode.dlc     = cfg_dlc;
  end

  gss_cfg_regs #(.POS_W(POS_W), .NIB_W(NIB_W), .RESERVE(RESERVE)) cfg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_mode   (cfg_mode),
    .cfg_offset (cfg_offset),
    .cal_strobe (cal_strobe),
    .raw_lo     (raw_pos[NIB_W-1:0]),
    .prev_hi    (prev_hi),
    .mode_q     (mode_q),
    .off_q      (off_q)
  );

  gss_align #(.POS_W(POS_W), .NIB_W(NIB_W), .RESERVE(RESERVE)) align_i (
    .raw_pos (raw_pos),
    .off_q   (off_q),
    .prev_hi (prev_hi),
    .corr    (corr),
    .turn    (turn),
    .dev_big (dev_big)
  );

  gss_out #(.POS_W(POS_W), .NIB_W(NIB_W)) out_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_q  (mode_q),
    .corr    (corr),
    .turn    (turn),
    .dev_big (dev_big),
    .pos_q   (pos_out),
    .hi_q    (next_hi),
    .err_q   (sync_err)
  );

endmodule

// File: rtl/gss_checker.sv
module gss_checker
  import gss_pkg::*;
#(
  parameter int POS_W   = 8,
  parameter int NIB_W   = 4,
  parameter int RESERVE = 4,
  localparam int HI_W   = POS_W - NIB_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [POS_W-1:0] raw_pos,
  input logic [NIB_W-1:0] prev_hi,
  input logic             cfg_wr,
  input logic             cal_strobe,
  input logic             sync_q,
  input logic             chk_q,
  input logic [DLC_W-1:0] dlc_q,
  input logic [POS_W-1:0] off_q,
  input logic [POS_W-1:0] pos_out,
  input logic [NIB_W-1:0] next_hi,
  input logic             sync_err
);

  assert_full_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_q && dlc_q == DLC_SYNC) |=>
      pos_out == POS_W'($past(raw_pos) + $past(off_q)));

  assert_next_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> next_hi == NIB_W'((POS_W'($past(raw_pos) + $past(off_q))) >> HI_W));

  assert_cal_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_strobe && !sync_q) |=>
      off_q == POS_W'(NIB_W'($past(prev_hi) - $past(raw_pos[NIB_W-1:0]) + NIB_W'(RESERVE))));

  assert_cal_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_strobe && sync_q && !cfg_wr) |=> $stable(off_q));

  assert_turn_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q && dlc_q == DLC_SYNC) |=> pos_out[POS_W-1:HI_W] == '0);

  assert_err_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(chk_q && dlc_q == DLC_SYNC) |=> !sync_err);

endmodule

bind gear_stage_sync gss_checker #(.POS_W(POS_W), .NIB_W(NIB_W), .RESERVE(RESERVE)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .raw_pos    (raw_pos),
  .prev_hi    (prev_hi),
  .cfg_wr     (cfg_wr),
  .cal_strobe (cal_strobe),
  .sync_q     (mode_q.sync_en),
  .chk_q      (mode_q.chk_en),
  .dlc_q      (mode_q.dlc),
  .off_q      (off_q),
  .pos_out    (pos_out),
  .next_hi    (next_hi),
  .sync_err   (sync_err)
);

// File: tb/gear_stage_sync_tb_top.sv
`timescale 1ns/1ps
module gear_stage_sync_tb_top;

  logic       clk;
  logic       rst_n;
  logic [7:0] raw_pos;
  logic [3:0] prev_hi;
  logic       cfg_wr;
  logic       cfg_sync_en;
  logic       cfg_chk_en;
  logic [2:0] cfg_dlc;
  logic [7:0] cfg_offset;
  logic       cal_strobe;
  logic [7:0] pos_out;
  logic [3:0] next_hi;
  logic       sync_err;

  int checks;
  int failures;

  // model of the configuration registers
  logic       m_sync;
  logic       m_chk;
  logic [2:0] m_dlc;
  logic [7:0] m_off;

  gear_stage_sync dut_i (
    .clk(clk), .rst_n(rst_n), .raw_pos(raw_pos), .prev_hi(prev_hi),
    .cfg_wr(cfg_wr), .cfg_sync_en(cfg_sync_en), .cfg_chk_en(cfg_chk_en),
    .cfg_dlc(cfg_dlc), .cfg_offset(cfg_offset), .cal_strobe(cal_strobe),
    .pos_out(pos_out), .next_hi(next_hi), .sync_err(sync_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic signed [3:0] f_dev(input logic [7:0] r, input logic [7:0] o,
                                              input logic [3:0] p);
    logic [7:0] t;
    t = r + o - 8'd4;
    return t[3:0] - p;
  endfunction

  function automatic logic [3:0] f_turn(input logic [7:0] r, input logic [7:0] o,
                                        input logic [3:0] p);
    logic [7:0] t;
    logic signed [3:0] d;
    logic [7:0] s;
    t = r + o - 8'd4;
    d = f_dev(r, o, p);
    s = t - {{4{d[3]}}, d};
    return s[7:4];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: compute expectations from the model, clock, update model, check
  task automatic run_cycle();
    logic [7:0] e_pos;
    logic [3:0] e_hi;
    logic       e_err;
    logic       syncm;
    logic       chkm;
    logic signed [3:0] d;
    logic [7:0] sum;
    syncm = m_sync && (m_dlc == 3'h3);
    chkm  = m_chk && (m_dlc == 3'h3);
    sum   = raw_pos + m_off;
    d     = f_dev(raw_pos, m_off, prev_hi);
    e_pos = syncm ? {4'h0, f_turn(raw_pos, m_off, prev_hi)} : sum;
    e_hi  = sum[7:4];
    e_err = chkm && ((d > 4) || (d < -4));
    @(posedge clk);
    if (cal_strobe && !m_sync) m_off = {4'h0, prev_hi - raw_pos[3:0] + 4'd4};
    else if (cfg_wr) m_off = cfg_offset;
    if (cfg_wr) begin
      m_sync = cfg_sync_en; m_chk = cfg_chk_en; m_dlc = cfg_dlc;
    end
    @(negedge clk);
    check(syncm ? "R7 turn count" : "R3 corrected angle", int'(pos_out), int'(e_pos));
    check("R4 next_hi", int'(next_hi), int'(e_hi));
    check(chkm ? "R8 sync_err" : "R9 sync_err gated", int'(sync_err), int'(e_err));
    cfg_wr = 1'b0;
    cal_strobe = 1'b0;
  endtask

  task automatic write_cfg(input logic s, input logic c, input logic [2:0] dl,
                           input logic [7:0] o);
    cfg_wr = 1'b1; cfg_sync_en = s; cfg_chk_en = c; cfg_dlc = dl; cfg_offset = o;
    run_cycle();
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    m_sync = 0; m_chk = 0; m_dlc = 0; m_off = 0;
    rst_n = 1'b0; raw_pos = 8'h5A; prev_hi = 4'h3; cfg_wr = 0; cfg_sync_en = 0;
    cfg_chk_en = 0; cfg_dlc = 0; cfg_offset = 0; cal_strobe = 0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R1 pos_out in reset", int'(pos_out), 0);
    check("R1 next_hi in reset", int'(next_hi), 0);
    check("R1 sync_err in reset", int'(sync_err), 0);
    rst_n = 1'b1;
    // offset cleared by reset: pos_out follows raw
    run_cycle();
    check("R1 offset cleared", int'(pos_out), 'h5A);

    // R5 calibration: prev 5, raw 0x32 -> offset 7
    write_cfg(1'b0, 1'b0, 3'h7, 8'h00);
    raw_pos = 8'h32; prev_hi = 4'h5; cal_strobe = 1'b1;
    run_cycle();
    raw_pos = 8'h00;
    run_cycle();
    check("R5 calibrated offset", int'(pos_out), 'h07);

    // R2 priority: cal wins over cfg_offset in same cycle
    raw_pos = 8'h10; prev_hi = 4'h9; cal_strobe = 1'b1;
    write_cfg(1'b0, 1'b0, 3'h7, 8'hC3);
    raw_pos = 8'h00;
    run_cycle();
    check("R2 cal over cfg_offset", int'(pos_out), 'h0D);

    // enter sync mode with offset 7, check enabled
    write_cfg(1'b1, 1'b1, 3'h3, 8'h07);
    // R6: cal ignored while sync set
    raw_pos = 8'hF0; prev_hi = 4'h2; cal_strobe = 1'b1;
    run_cycle();
    write_cfg(1'b0, 1'b0, 3'h7, 8'h07);
    raw_pos = 8'h00;
    run_cycle();
    check("R6 offset unchanged after ignored cal", int'(pos_out), 'h07);
    write_cfg(1'b1, 1'b1, 3'h3, 8'h07);

    // R7 directed: aligned, lagging, wrap
    raw_pos = 8'h32; prev_hi = 4'h5; run_cycle();
    check("R7 aligned turn", int'(pos_out), 3);
    raw_pos = 8'h32; prev_hi = 4'h6; run_cycle();
    check("R7 lagging turn", int'(pos_out), 3);
    raw_pos = 8'h3E; prev_hi = 4'h0; run_cycle();
    check("R7 wrap turn", int'(pos_out), 4);
    // R8 boundaries: d = 4, 5, -4, -8
    raw_pos = 8'h32; prev_hi = 4'h1; run_cycle();
    check("R8 d=4 no error", int'(sync_err), 0);
    prev_hi = 4'h0; run_cycle();
    check("R8 d=5 error", int'(sync_err), 1);
    prev_hi = 4'h9; run_cycle();
    check("R8 d=-4 no error", int'(sync_err), 0);
    prev_hi = 4'hD; run_cycle();
    check("R8 d=-8 error", int'(sync_err), 1);
    // R9: check bit with other code
    write_cfg(1'b1, 1'b1, 3'h7, 8'h07);
    prev_hi = 4'hD; run_cycle();
    check("R9 wrong code no error", int'(sync_err), 0);

    // constrained random
    for (int i = 0; i < 2000; i++) begin
      int k;
      raw_pos = 8'($urandom);
      prev_hi = 4'($urandom);
      cal_strobe = (($urandom % 8) == 0);
      if (($urandom % 12) == 0) begin
        cfg_wr = 1'b1;
        cfg_sync_en = 1'($urandom);
        cfg_chk_en = 1'($urandom);
        k = int'($urandom % 4);
        cfg_dlc = (k < 2) ? 3'h3 : (k == 2) ? 3'h7 : 3'($urandom);
        cfg_offset = 8'($urandom);
      end
      run_cycle();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule